// File: doc/BRIEF.md
# Expansion ROM Access Timer

This block runs single read or write cycles to an external byte-wide ROM or flash part over an 8-bit address bus and an 8-bit data bus. Each access holds a strobe for a programmable number of clock periods. The block keeps that count in a small timing register and multiplies it by a clock factor of one or two. For reads, the block captures the device's data on the final clock of the window. It then raises a single-cycle completion pulse.

A hard reset loads the timing register with binary 1001, which is a 9-period window. Software may rewrite the register only while the controller reports it is stopped. A soft reset and changes of the stop status leave the register untouched. A soft reset does abort any access in flight. The requester holds its request high until the strobe for its access appears. A request made during an access waits until that access has finished.

Top module: `xrom_access_timer`

## Requirements
- R1: While hard reset (`rst_n` low) is active and right after it ends, `tmg_rd` reads binary 1001 and `xb_rd`, `xb_wr` and `done` are all low.
- R2: A request accepted from idle with `req_wr`=0 raises `xb_rd` from the cycle after the accepting edge. `xb_rd` stays high for exactly N consecutive cycles, where N = max(T,1) × F and T is the timing register value. `xb_addr` equals the requested address throughout.
- R3: The clock factor F is 1 when `clk_fac`=0 and 2 when `clk_fac`=1. Its value is taken at the accepting edge.
- R4: With `req_wr`=1, the window is driven on `xb_wr` instead of `xb_rd`, with the same length rule. `xb_dout_en` is high and `xb_dout` equals the requested write data throughout. `xb_rd` and `xb_wr` are never high together.
- R5: For a read, the value on `xb_din` at the clock edge that ends the last window cycle appears on `rdata`. In the cycle after the window, `done` is high for exactly one cycle.
- R6: `tmg_rd` always shows the timing register. A write (`tmg_we`=1) loads `tmg_wd` only when `stop`=1 and is ignored when `stop`=0.
- R7: A timing value of 0 gives a window of one cycle times F.
- R8: A soft reset (`soft_rst`=1) leaves the timing register unchanged. It ends any access, so that in the next cycle both strobes are low, and it produces no `done` for the aborted access.
- R9: Changing `stop` alone never changes the timing register.
- R10: A request raised while an access is in progress does not disturb it. The request is accepted at the earliest at the edge that ends the `done` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hard reset, asynchronous, active low |
| soft_rst | input | 1 | Soft reset, synchronous, active high |
| stop | input | 1 | Controller stopped status; enables timing writes |
| tmg_we | input | 1 | Timing register write strobe |
| tmg_wd | input | 4 | Timing register write data |
| tmg_rd | output | 4 | Timing register read data |
| clk_fac | input | 1 | Clock factor select: 0 = ×1, 1 = ×2 |
| req | input | 1 | Access request, held until the strobe appears |
| req_wr | input | 1 | 1 = write access, 0 = read access |
| req_addr | input | 8 | Access address |
| req_wdata | input | 8 | Write data |
| xb_addr | output | 8 | External address bus |
| xb_dout | output | 8 | External write data |
| xb_dout_en | output | 1 | Drive enable for external data |
| xb_din | input | 8 | External read data |
| xb_rd | output | 1 | Read strobe |
| xb_wr | output | 1 | Write strobe |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 8 | Captured read data |

## Verification
The modelled device drives valid data only on the final window cycle and a marker value before that. A design that captured data one cycle early, or that miscounted the window, returns the marker or shows the wrong strobe length. The cases covered are a zero timing value, the maximum value with the doubled factor, timing writes while running, a soft reset in the middle of an access, and a second request raised during a busy window. Each targets a specific failure: an unguarded register that takes writes while running, a soft reset that reloads the register or lets a `done` escape, and a sequencer that takes a new address partway through a window.

// File: rtl/xrom_pkg.sv
package xrom_pkg;
   typedef enum logic {
      XS_IDLE = 1'b0,
      XS_ACT  = 1'b1
   } xs_e;
endpackage

// File: rtl/xrom_tmg_reg.sv
module xrom_tmg_reg #(
   parameter int             TMG_W   = 4,
   parameter logic [TMG_W-1:0] TMG_RST = 4'b1001
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             stop,
   input  logic             we,
   input  logic [TMG_W-1:0] wd,
   output logic [TMG_W-1:0] q
);
   // Only hard reset loads the default; soft reset is not an input here.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          q <= TMG_RST;
      else if (we && stop) q <= wd;
   end
endmodule

// File: rtl/xrom_win_cnt.sv
module xrom_win_cnt #(
   parameter int TMG_W  = 4,
   parameter bit FAC_EN = 1'b1,
   localparam int CNT_W = TMG_W + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             load,
   input  logic [TMG_W-1:0] tmg,
   input  logic             fac,
   output logic             last
);
   logic [CNT_W-1:0] base;
   logic [CNT_W-1:0] len;
   logic [CNT_W-1:0] cnt;

   assign base = (tmg == '0) ? CNT_W'(1) : {1'b0, tmg};

   generate
      if (FAC_EN) begin : g_fac
         assign len = fac ? (base << 1) : base;
      end else begin : g_nofac
         logic unused_fac;
         assign unused_fac = fac;
         assign len = base;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt <= '0;
      else if (clr)        cnt <= '0;
      else if (load)       cnt <= len;
      else if (cnt != '0)  cnt <= cnt - CNT_W'(1);
   end

   assign last = (cnt == CNT_W'(1));
endmodule

// File: rtl/xrom_access_timer.sv
module xrom_access_timer
   import xrom_pkg::*;
#(
   parameter int               AW      = 8,
   parameter int               DW      = 8,
   parameter int               TMG_W   = 4,
   parameter logic [TMG_W-1:0] TMG_RST = 4'b1001,
   parameter bit               FAC_EN  = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             soft_rst,
   input  logic             stop,
   input  logic             tmg_we,
   input  logic [TMG_W-1:0] tmg_wd,
   output logic [TMG_W-1:0] tmg_rd,
   input  logic             clk_fac,
   input  logic             req,
   input  logic             req_wr,
   input  logic [AW-1:0]    req_addr,
   input  logic [DW-1:0]    req_wdata,
   output logic [AW-1:0]    xb_addr,
   output logic [DW-1:0]    xb_dout,
   output logic             xb_dout_en,
   input  logic [DW-1:0]    xb_din,
   output logic             xb_rd,
   output logic             xb_wr,
   output logic             done,
   output logic [DW-1:0]    rdata
);
   generate
      if (TMG_W < 2 || TMG_W > 8) begin : g_bad_tmg
         $error("xrom_access_timer: TMG_W out of range");
      end
      if (AW < 1 || DW < 1) begin : g_bad_bus
         $error("xrom_access_timer: bus widths must be positive");
      end
   endgenerate

   xs_e           st;
   logic          lat_wr;
   logic [AW-1:0] lat_addr;
   logic [DW-1:0] lat_wdata;
   logic          accept;
   logic          last;

   assign accept = (st == XS_IDLE) && req && !soft_rst;

   xrom_tmg_reg #(.TMG_W(TMG_W), .TMG_RST(TMG_RST)) u_tmg (
      .clk   (clk),
      .rst_n (rst_n),
      .stop  (stop),
      .we    (tmg_we),
      .wd    (tmg_wd),
      .q     (tmg_rd)
   );

   xrom_win_cnt #(.TMG_W(TMG_W), .FAC_EN(FAC_EN)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (soft_rst),
      .load  (accept),
      .tmg   (tmg_rd),
      .fac   (clk_fac),
      .last  (last)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= XS_IDLE;
         lat_wr    <= 1'b0;
         lat_addr  <= '0;
         lat_wdata <= '0;
         rdata     <= '0;
         done      <= 1'b0;
      end else if (soft_rst) begin
         st   <= XS_IDLE;
         done <= 1'b0;
      end else begin
         done <= 1'b0;
         case (st)
            XS_IDLE: if (accept) begin
               lat_wr    <= req_wr;
               lat_addr  <= req_addr;
               lat_wdata <= req_wdata;
               st        <= XS_ACT;
            end
            XS_ACT: if (last) begin
               if (!lat_wr) rdata <= xb_din;
               done <= 1'b1;
               st   <= XS_IDLE;
            end
            default: st <= XS_IDLE;
         endcase
      end
   end

   assign xb_rd      = (st == XS_ACT) && !lat_wr;
   assign xb_wr      = (st == XS_ACT) && lat_wr;
   assign xb_dout_en = xb_wr;
   assign xb_addr    = lat_addr;
   assign xb_dout    = lat_wdata;
endmodule

// File: rtl/xrom_access_timer_chk.sv
module xrom_access_timer_chk #(
   parameter int TMG_W = 4,
   parameter int AW    = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             soft_rst,
   input logic             stop,
   input logic             tmg_we,
   input logic [TMG_W-1:0] tmg_rd,
   input logic [AW-1:0]    xb_addr,
   input logic             xb_rd,
   input logic             xb_wr,
   input logic             done
);
   logic stb;
   assign stb = xb_rd | xb_wr;

   a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   a_r5_done_after_window: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> $past(stb));

   a_r4_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      !(xb_rd && xb_wr));

   a_r10_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
      stb |=> (!stb || $stable(xb_addr)));

   a_r6_tmg_locked: assert property (@(posedge clk) disable iff (!rst_n)
      (!tmg_we || !stop) |=> $stable(tmg_rd));

   a_r8_soft_abort: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> (!stb && !done));
endmodule

bind xrom_access_timer xrom_access_timer_chk #(.TMG_W(TMG_W), .AW(AW)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .soft_rst (soft_rst),
   .stop     (stop),
   .tmg_we   (tmg_we),
   .tmg_rd   (tmg_rd),
   .xb_addr  (xb_addr),
   .xb_rd    (xb_rd),
   .xb_wr    (xb_wr),
   .done     (done)
);

// File: tb/sim_xrom_access_timer.sv
`timescale 1ns/1ps
module sim_xrom_access_timer;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       soft_rst = 1'b0;
   logic       stop = 1'b0;
   logic       tmg_we = 1'b0;
   logic [3:0] tmg_wd = '0;
   logic [3:0] tmg_rd;
   logic       clk_fac = 1'b0;
   logic       req = 1'b0;
   logic       req_wr = 1'b0;
   logic [7:0] req_addr = '0;
   logic [7:0] req_wdata = '0;
   logic [7:0] xb_addr, xb_dout, xb_din, rdata;
   logic       xb_dout_en, xb_rd, xb_wr, done;
   logic       stb;

   int checks = 0;
   int fails  = 0;
   int mon_cnt = 0;
   int rom_n = 0;
   bit mon_addr_ok = 1'b1;

   typedef struct {
      logic [7:0] addr;
      logic       wr;
      logic [7:0] wd;
      int         n;
      string      tag;
   } exp_t;
   exp_t sb[$];

   always #5 clk = ~clk;

   xrom_access_timer u0 (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .stop(stop),
      .tmg_we(tmg_we), .tmg_wd(tmg_wd), .tmg_rd(tmg_rd), .clk_fac(clk_fac),
      .req(req), .req_wr(req_wr), .req_addr(req_addr), .req_wdata(req_wdata),
      .xb_addr(xb_addr), .xb_dout(xb_dout), .xb_dout_en(xb_dout_en),
      .xb_din(xb_din), .xb_rd(xb_rd), .xb_wr(xb_wr), .done(done), .rdata(rdata)
   );

   assign stb = xb_rd | xb_wr;
   // Slow device: valid data only on the final window cycle.
   assign xb_din = (xb_rd && mon_cnt == rom_n) ? ~xb_addr : 8'hEE;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // Monitor: scoreboard consumer.
   always @(negedge clk) begin
      if (stb) begin
         if (mon_cnt == 0 && sb.size() > 0) begin
            rom_n = sb[0].n;
            mon_addr_ok = 1'b1;
         end
         if (sb.size() > 0) begin
            if (xb_addr != sb[0].addr) mon_addr_ok = 1'b0;
            if (sb[0].wr && (!xb_dout_en || xb_dout != sb[0].wd)) mon_addr_ok = 1'b0;
            if (sb[0].wr != xb_wr) mon_addr_ok = 1'b0;
         end
         mon_cnt++;
      end
      if (done) begin
         if (sb.size() == 0) begin
            chk(1'b0, "R5 unexpected done", 1, 0);
         end else begin
            exp_t e;
            e = sb.pop_front();
            chk(mon_cnt == e.n, {e.tag, " window length (R2)"}, mon_cnt, e.n);
            chk(mon_addr_ok, {e.tag, " address/data/strobe held (R4 R10)"}, int'(mon_addr_ok), 1);
            if (!e.wr)
               chk(rdata == ~e.addr, {e.tag, " read data from last cycle (R5)"}, int'(rdata), int'(~e.addr));
         end
         mon_cnt = 0;
      end
   end

   task automatic do_acc(input logic [7:0] a, input logic w, input logic [7:0] d,
                         input int n, input string tag);
      exp_t e;
      e.addr = a; e.wr = w; e.wd = d; e.n = n; e.tag = tag;
      sb.push_back(e);
      @(negedge clk);
      req = 1'b1; req_wr = w; req_addr = a; req_wdata = d;
      while (stb) @(negedge clk);
      while (!stb) @(negedge clk);
      req = 1'b0;
   endtask

   task automatic wait_done();
      while (sb.size() != 0) @(negedge clk);
      @(negedge clk);
   endtask

   task automatic tmg_write(input logic [3:0] v, input logic s);
      @(negedge clk);
      stop = s; tmg_we = 1'b1; tmg_wd = v;
      @(negedge clk);
      tmg_we = 1'b0; stop = 1'b0;
   endtask

   initial begin
      #2_000_000;
      chk(1'b0, "watchdog", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(tmg_rd == 4'b1001, "R1 timing default in reset", int'(tmg_rd), 9);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!stb && !done && tmg_rd == 4'b1001, "R1 idle after reset",
          int'({stb, done, tmg_rd}), 9);

      // R2 R3: default timing, factor 1 then 2.
      clk_fac = 1'b0;
      do_acc(8'h12, 1'b0, 8'h00, 9, "R2 read x1");
      wait_done();
      clk_fac = 1'b1;
      do_acc(8'h34, 1'b0, 8'h00, 18, "R3 read x2");
      wait_done();

      // R6: write ignored while not stopped, taken while stopped.
      tmg_write(4'd3, 1'b0);
      chk(tmg_rd == 4'b1001, "R6 write ignored without stop", int'(tmg_rd), 9);
      tmg_write(4'd3, 1'b1);
      chk(tmg_rd == 4'd3, "R6 write taken with stop", int'(tmg_rd), 3);

      // R9: toggling stop alone.
      @(negedge clk); stop = 1'b1;
      @(negedge clk); stop = 1'b0;
      @(negedge clk);
      chk(tmg_rd == 4'd3, "R9 stop toggle keeps timing", int'(tmg_rd), 3);

      // R4: write access.
      clk_fac = 1'b0;
      do_acc(8'h40, 1'b1, 8'h5A, 3, "R4 write x1");
      wait_done();

      // R10: second request raised during a busy window.
      clk_fac = 1'b1;
      do_acc(8'h21, 1'b0, 8'h00, 6, "R10 first");
      do_acc(8'h22, 1'b0, 8'h00, 6, "R10 second");
      wait_done();

      // R7: zero timing value.
      tmg_write(4'd0, 1'b1);
      clk_fac = 1'b0;
      do_acc(8'h33, 1'b0, 8'h00, 1, "R7 zero x1");
      wait_done();
      clk_fac = 1'b1;
      do_acc(8'h35, 1'b1, 8'hC3, 2, "R7 zero x2");
      wait_done();

      // Maximum window.
      tmg_write(4'd15, 1'b1);
      do_acc(8'h7F, 1'b0, 8'h00, 30, "R2 max x2");
      wait_done();

      // R8: soft reset mid-access.
      clk_fac = 1'b0;
      do_acc(8'h44, 1'b0, 8'h00, 15, "R8 aborted");
      repeat (3) @(negedge clk);
      soft_rst = 1'b1;
      @(negedge clk);
      soft_rst = 1'b0;
      chk(!stb && !done, "R8 strobes low after soft reset", int'({stb, done}), 0);
      chk(tmg_rd == 4'd15, "R8 timing kept by soft reset", int'(tmg_rd), 15);
      #1;
      sb.delete();
      mon_cnt = 0;
      begin
         bit seen_done = 1'b0;
         for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (done || stb) seen_done = 1'b1;
         end
         chk(!seen_done, "R8 no done for aborted access", int'(seen_done), 0);
      end

      // Operation resumes after soft reset.
      do_acc(8'h55, 1'b0, 8'h00, 15, "R8 after abort");
      wait_done();

      repeat (3) @(negedge clk);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule